// File: doc/BRIEF.md
# Integer Execute Unit

This block is the execute stage of a small 32-bit integer core, built as pure combinational logic. It takes the fetched instruction word together with the two register values that the register file returned for the instruction's first and second source fields. In the same cycle it yields the computed value, the destination register number, a register write enable, a signed-overflow flag and, for memory references, the effective byte address.

Inside, a decoder turns the opcode and function fields into a compact bundle of control strobes. A datapath uses those strobes to pick the second operand, sign- or zero-extend the immediate, run one shared adder/subtractor, the bitwise operations and a logarithmic left shifter, and gate the outputs. Register reads, memory access, branch resolution and pipeline control are handled by neighbouring blocks.

Top module: `int_exec_unit`

## Requirements
- R1: With op (bits 31:26) equal to 0 and shamt (bits 10:6) equal to 0, funct (bits 5:0) 0x20/0x21 gives rs+rt and 0x22/0x23 gives rs-rt, both modulo 2^32. The destination is rd (bits 15:11).
- R2: With op 0 and shamt 0, funct 0x24, 0x25, 0x26 and 0x27 give rs AND rt, rs OR rt, rs XOR rt and NOT(rs OR rt). The destination is rd.
- R3: With op 0, bits 25:21 zero and funct 0, the result is rt shifted left by shamt, with zeros shifted in. The destination is rd.
- R4: add (funct 0x20), sub (funct 0x22) and addi (op 0x08) raise overflow when the two's-complement result does not fit in 32 bits. While overflow is high, write enable is 0, the destination number is still reported and the result is the wrapped value.
- R5: addu (0x21), subu (0x23) and addiu (op 0x09) never raise overflow. Overflow is 0 for every other instruction as well.
- R6: addi (op 0x08) and addiu (op 0x09) give rs plus the sign-extended bits 15:0. The destination is rt (bits 20:16).
- R7: andi (op 0x0C), ori (0x0D) and xori (0x0E) combine rs with bits 15:0 zero-extended. The destination is rt.
- R8: lui (op 0x0F) gives bits 15:0 placed in result bits 31:16, with result bits 15:0 zero. The destination is rt.
- R9: lw (op 0x23) puts rs plus the sign-extended offset on the address output. The destination is rt and the result is 0.
- R10: sw (op 0x2B) puts rs plus the sign-extended offset on the address output. Result, destination and write enable are 0.
- R11: Any other op/funct/field combination gives 0 on result, destination, write enable, overflow and address.
- R12: Write enable is 1 only for a recognized, non-store instruction without overflow whose destination number is not 0.
- R13: The address output is 0 for every instruction other than lw and sw.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instrWord | input | 32 | Instruction word under execution |
| rsVal | input | 32 | Value of the register named by bits 25:21 |
| rtVal | input | 32 | Value of the register named by bits 20:16 |
| result | output | 32 | Computed value for write-back |
| destReg | output | 5 | Destination register number |
| writeEn | output | 1 | Register write request |
| overflow | output | 1 | Signed overflow of add, sub or addi |
| memAddr | output | 32 | Effective address for lw and sw |

## Verification
The block holds no state, so a fault in decoding or operand selection shows up on the ports in the same cycle as the instruction that triggers it. A wrong extension mode, for example, gives a wrong sum or address for every negative immediate. A misrouted destination field shows up as a wrong register number, or as a write enable that stays high for register 0. The sweep drives every opcode paired with every funct value under several field and operand patterns. Each field of the output is compared against an arithmetic model, so a single mis-decoded code is caught on its first appearance.

// File: rtl/exu_pkg.sv
package exu_pkg;

  localparam int INSTR_W = 32;
  localparam int REG_AW  = 5;
  localparam int IMM_W   = 16;
  localparam int CODE_W  = 6;

  localparam logic [CODE_W-1:0] OP_SPECIAL = 6'h00;
  localparam logic [CODE_W-1:0] OP_ADDI    = 6'h08;
  localparam logic [CODE_W-1:0] OP_ADDIU   = 6'h09;
  localparam logic [CODE_W-1:0] OP_ANDI    = 6'h0C;
  localparam logic [CODE_W-1:0] OP_ORI     = 6'h0D;
  localparam logic [CODE_W-1:0] OP_XORI    = 6'h0E;
  localparam logic [CODE_W-1:0] OP_LUI     = 6'h0F;
  localparam logic [CODE_W-1:0] OP_LW      = 6'h23;
  localparam logic [CODE_W-1:0] OP_SW      = 6'h2B;

  localparam logic [CODE_W-1:0] FN_SLL  = 6'h00;
  localparam logic [CODE_W-1:0] FN_ADD  = 6'h20;
  localparam logic [CODE_W-1:0] FN_ADDU = 6'h21;
  localparam logic [CODE_W-1:0] FN_SUB  = 6'h22;
  localparam logic [CODE_W-1:0] FN_SUBU = 6'h23;
  localparam logic [CODE_W-1:0] FN_AND  = 6'h24;
  localparam logic [CODE_W-1:0] FN_OR   = 6'h25;
  localparam logic [CODE_W-1:0] FN_XOR  = 6'h26;
  localparam logic [CODE_W-1:0] FN_NOR  = 6'h27;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR, ALU_SLL, ALU_LUI
  } aluSelT;

  typedef enum logic [1:0] {
    IMM_NONE, IMM_SIGN, IMM_ZERO
  } immModeT;

  typedef enum logic [1:0] {
    DST_NONE, DST_RD, DST_RT
  } dstSelT;

  typedef struct packed {
    logic    valid;
    aluSelT  alu;
    immModeT imm;
    dstSelT  dst;
    logic    trapOvf;
    logic    memRef;
  } ctrlT;

endpackage

// File: rtl/exu_decode.sv
module exu_decode
  import exu_pkg::*;
(
  input  logic [CODE_W-1:0] opCode,
  input  logic [CODE_W-1:0] funct,
  input  logic [REG_AW-1:0] rsField,
  input  logic [REG_AW-1:0] shamt,
  output ctrlT              ctrl
);

  logic shamtZero;
  logic rsZero;

  assign shamtZero = (shamt == '0);
  assign rsZero    = (rsField == '0);

  always_comb begin
    ctrl = '{valid: 1'b0, alu: ALU_ADD, imm: IMM_NONE, dst: DST_NONE,
             trapOvf: 1'b0, memRef: 1'b0};
    unique case (opCode)
      OP_SPECIAL: begin
        if (funct == FN_SLL) begin
          if (rsZero) begin
            ctrl.valid = 1'b1;
            ctrl.alu   = ALU_SLL;
            ctrl.dst   = DST_RD;
          end
        end else if (shamtZero) begin
          ctrl.dst   = DST_RD;
          ctrl.valid = 1'b1;
          case (funct)
            FN_ADD:  begin ctrl.alu = ALU_ADD; ctrl.trapOvf = 1'b1; end
            FN_ADDU: ctrl.alu = ALU_ADD;
            FN_SUB:  begin ctrl.alu = ALU_SUB; ctrl.trapOvf = 1'b1; end
            FN_SUBU: ctrl.alu = ALU_SUB;
            FN_AND:  ctrl.alu = ALU_AND;
            FN_OR:   ctrl.alu = ALU_OR;
            FN_XOR:  ctrl.alu = ALU_XOR;
            FN_NOR:  ctrl.alu = ALU_NOR;
            default: begin
              ctrl.valid = 1'b0;
              ctrl.dst   = DST_NONE;
            end
          endcase
        end
      end
      OP_ADDI: begin
        ctrl.valid = 1'b1; ctrl.alu = ALU_ADD; ctrl.imm = IMM_SIGN;
        ctrl.dst = DST_RT; ctrl.trapOvf = 1'b1;
      end
      OP_ADDIU: begin
        ctrl.valid = 1'b1; ctrl.alu = ALU_ADD; ctrl.imm = IMM_SIGN;
        ctrl.dst = DST_RT;
      end
      OP_ANDI: begin
        ctrl.valid = 1'b1; ctrl.alu = ALU_AND; ctrl.imm = IMM_ZERO;
        ctrl.dst = DST_RT;
      end
      OP_ORI: begin
        ctrl.valid = 1'b1; ctrl.alu = ALU_OR; ctrl.imm = IMM_ZERO;
        ctrl.dst = DST_RT;
      end
      OP_XORI: begin
        ctrl.valid = 1'b1; ctrl.alu = ALU_XOR; ctrl.imm = IMM_ZERO;
        ctrl.dst = DST_RT;
      end
      OP_LUI: begin
        ctrl.valid = 1'b1; ctrl.alu = ALU_LUI; ctrl.dst = DST_RT;
      end
      OP_LW: begin
        ctrl.valid = 1'b1; ctrl.alu = ALU_ADD; ctrl.imm = IMM_SIGN;
        ctrl.dst = DST_RT; ctrl.memRef = 1'b1;
      end
      OP_SW: begin
        ctrl.valid = 1'b1; ctrl.alu = ALU_ADD; ctrl.imm = IMM_SIGN;
        ctrl.dst = DST_NONE; ctrl.memRef = 1'b1;
      end
      default: ;
    endcase
  end

  // R5: only the trapping codes may ask for an overflow check
  always_comb begin
    if (ctrl.trapOvf) begin
      a_r5_trap_codes: assert ((opCode == OP_ADDI) ||
        (opCode == OP_SPECIAL && (funct == FN_ADD || funct == FN_SUB)))
        else $error("R5 overflow check on non-trapping code");
    end
  end

endmodule

// File: rtl/exu_datapath.sv
module exu_datapath
  import exu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [IMM_W-1:0]  immField,
  input  logic [REG_AW-1:0] shamt,
  input  logic [DATA_W-1:0] rsVal,
  input  logic [DATA_W-1:0] rtVal,
  input  ctrlT              ctrl,
  output logic [DATA_W-1:0] result,
  output logic              ovf,
  output logic [DATA_W-1:0] memAddr
);

  localparam int MSB    = DATA_W - 1;
  localparam int EXT_W  = DATA_W - IMM_W;
  localparam int STAGES = REG_AW;

  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] opB;
  logic [DATA_W-1:0] bEff;
  logic [DATA_W-1:0] sum;
  logic              doSub;
  logic              ovfRaw;
  logic [DATA_W-1:0] aluOut;
  logic [DATA_W-1:0] shiftStage [0:STAGES];

  always_comb begin
    unique case (ctrl.imm)
      IMM_SIGN: immExt = {{EXT_W{immField[IMM_W-1]}}, immField};
      IMM_ZERO: immExt = {{EXT_W{1'b0}}, immField};
      default:  immExt = '0;
    endcase
  end

  assign opB   = (ctrl.imm == IMM_NONE) ? rtVal : immExt;
  assign doSub = (ctrl.alu == ALU_SUB);
  assign bEff  = doSub ? ~opB : opB;
  assign sum   = rsVal + bEff + {{(DATA_W-1){1'b0}}, doSub};

  // Sign of both addends agrees but the sum's sign differs
  assign ovfRaw = (rsVal[MSB] == bEff[MSB]) && (sum[MSB] != rsVal[MSB]);

  assign shiftStage[0] = rtVal;
  for (genvar k = 0; k < STAGES; k++) begin : g_shift
    assign shiftStage[k+1] = shamt[k] ? (shiftStage[k] << (1 << k))
                                      : shiftStage[k];
  end

  always_comb begin
    unique case (ctrl.alu)
      ALU_ADD: aluOut = sum;
      ALU_SUB: aluOut = sum;
      ALU_AND: aluOut = rsVal & opB;
      ALU_OR:  aluOut = rsVal | opB;
      ALU_XOR: aluOut = rsVal ^ opB;
      ALU_NOR: aluOut = ~(rsVal | opB);
      ALU_SLL: aluOut = shiftStage[STAGES];
      ALU_LUI: aluOut = {immField, {EXT_W{1'b0}}};
      default: aluOut = '0;
    endcase
  end

  assign result  = (ctrl.valid && !ctrl.memRef) ? aluOut : '0;
  assign ovf     = ctrl.valid && ctrl.trapOvf && ovfRaw;
  assign memAddr = (ctrl.valid && ctrl.memRef) ? sum : '0;

  // R8: the upper-half load leaves the lower half clear
  always_comb begin
    if (ctrl.valid && ctrl.alu == ALU_LUI) begin
      a_r8_lui_low_clear: assert (result[EXT_W-1:0] == '0)
        else $error("R8 lui low half not zero");
    end
  end

  // R3: shift by zero passes rt unchanged
  always_comb begin
    if (ctrl.valid && ctrl.alu == ALU_SLL && shamt == '0) begin
      a_r3_shift_zero: assert (result == rtVal)
        else $error("R3 zero shift altered value");
    end
  end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import exu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [DATA_W-1:0]  rsVal,
  input  logic [DATA_W-1:0]  rtVal,
  output logic [DATA_W-1:0]  result,
  output logic [REG_AW-1:0]  destReg,
  output logic               writeEn,
  output logic               overflow,
  output logic [DATA_W-1:0]  memAddr
);

  localparam int OP_LSB = INSTR_W - CODE_W;
  localparam int RS_LSB = OP_LSB - REG_AW;
  localparam int RT_LSB = RS_LSB - REG_AW;
  localparam int RD_LSB = RT_LSB - REG_AW;
  localparam int SA_LSB = RD_LSB - REG_AW;

  ctrlT              ctrl;
  logic [REG_AW-1:0] rdField;
  logic [REG_AW-1:0] rtField;
  logic              ovfInt;

  assign rdField = instrWord[RD_LSB +: REG_AW];
  assign rtField = instrWord[RT_LSB +: REG_AW];

  exu_decode u_decode (
    .opCode  (instrWord[OP_LSB +: CODE_W]),
    .funct   (instrWord[CODE_W-1:0]),
    .rsField (instrWord[RS_LSB +: REG_AW]),
    .shamt   (instrWord[SA_LSB +: REG_AW]),
    .ctrl    (ctrl)
  );

  exu_datapath #(.DATA_W(DATA_W)) u_datapath (
    .immField (instrWord[IMM_W-1:0]),
    .shamt    (instrWord[SA_LSB +: REG_AW]),
    .rsVal    (rsVal),
    .rtVal    (rtVal),
    .ctrl     (ctrl),
    .result   (result),
    .ovf      (ovfInt),
    .memAddr  (memAddr)
  );

  always_comb begin
    unique case (ctrl.dst)
      DST_RD:  destReg = rdField;
      DST_RT:  destReg = rtField;
      default: destReg = '0;
    endcase
  end

  assign overflow = ovfInt;
  assign writeEn  = ctrl.valid && (ctrl.dst != DST_NONE) &&
                    (destReg != '0) && !ovfInt;

  always_comb begin
    // R12: never write register zero
    if (writeEn) begin
      a_r12_no_zero_write: assert (destReg != '0)
        else $error("R12 write to register zero");
    end
    // R4: overflow blocks the write
    if (overflow) begin
      a_r4_ovf_blocks_write: assert (!writeEn)
        else $error("R4 write despite overflow");
    end
    // R11: unrecognized instruction leaves every output idle
    if (!ctrl.valid) begin
      a_r11_idle_outputs: assert (result == '0 && !writeEn && !overflow &&
                                  memAddr == '0 && destReg == '0)
        else $error("R11 outputs active for invalid code");
    end
    // R13: address only for memory references
    if (!ctrl.memRef) begin
      a_r13_addr_mem_only: assert (memAddr == '0)
        else $error("R13 address on non-memory instruction");
    end
  end

endmodule

// File: tb/int_exec_unit_test.sv
module int_exec_unit_test;

  logic        clk = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] rsVal = '0;
  logic [31:0] rtVal = '0;
  logic [31:0] result;
  logic [4:0]  destReg;
  logic        writeEn;
  logic        overflow;
  logic [31:0] memAddr;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit timedOut = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #4 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  int_exec_unit uut (
    .instrWord (instrWord),
    .rsVal     (rsVal),
    .rtVal     (rtVal),
    .result    (result),
    .destReg   (destReg),
    .writeEn   (writeEn),
    .overflow  (overflow),
    .memAddr   (memAddr)
  );

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic bit sOvf(input logic [31:0] a, input logic [31:0] b, input bit sub);
    longint sa, sb, r;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    r = sub ? sa - sb : sa + sb;
    return (r > 64'sd2147483647) || (r < -64'sd2147483648);
  endfunction

  task automatic model(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] eRes, output logic [4:0] eDst,
                       output logic eWe, output logic eOvf, output logic [31:0] eAddr,
                       output string tag);
    logic [5:0] op, fn;
    logic [4:0] rs, rt, rd, sa;
    logic [31:0] se, ze;
    bit ok;
    op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16];
    rd = ins[15:11]; sa = ins[10:6]; fn = ins[5:0];
    se = {{16{ins[15]}}, ins[15:0]};
    ze = {16'h0, ins[15:0]};
    eRes = '0; eDst = '0; eOvf = 1'b0; eAddr = '0; ok = 1'b1; tag = "R11";
    if (op == 6'h00 && fn == 6'h00 && rs == 5'd0) begin
      eRes = b << sa; eDst = rd; tag = "R3";
    end else if (op == 6'h00 && sa == 5'd0 && fn >= 6'h20 && fn <= 6'h27) begin
      eDst = rd;
      case (fn)
        6'h20: begin eRes = a + b; eOvf = sOvf(a, b, 1'b0); tag = eOvf ? "R4" : "R1"; end
        6'h21: begin eRes = a + b; tag = "R5"; end
        6'h22: begin eRes = a - b; eOvf = sOvf(a, b, 1'b1); tag = eOvf ? "R4" : "R1"; end
        6'h23: begin eRes = a - b; tag = "R5"; end
        6'h24: begin eRes = a & b; tag = "R2"; end
        6'h25: begin eRes = a | b; tag = "R2"; end
        6'h26: begin eRes = a ^ b; tag = "R2"; end
        default: begin eRes = ~(a | b); tag = "R2"; end
      endcase
    end else begin
      case (op)
        6'h08: begin eRes = a + se; eDst = rt; eOvf = sOvf(a, se, 1'b0); tag = eOvf ? "R4" : "R6"; end
        6'h09: begin eRes = a + se; eDst = rt; tag = "R6"; end
        6'h0C: begin eRes = a & ze; eDst = rt; tag = "R7"; end
        6'h0D: begin eRes = a | ze; eDst = rt; tag = "R7"; end
        6'h0E: begin eRes = a ^ ze; eDst = rt; tag = "R7"; end
        6'h0F: begin eRes = {ins[15:0], 16'h0}; eDst = rt; tag = "R8"; end
        6'h23: begin eAddr = a + se; eDst = rt; tag = "R9"; end
        6'h2B: begin eAddr = a + se; tag = "R10"; end
        default: ok = 1'b0;
      endcase
    end
    eWe = ok && (eDst != 5'd0) && !eOvf;
    if (eWe == 1'b0 && ok && eDst == 5'd0 && op != 6'h2B) tag = "R12";
  endtask

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp, input logic [31:0] ins);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s ins=%h actual=%h expected=%h", tag, what, ins, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] eRes, eAddr;
    logic [4:0]  eDst;
    logic        eWe, eOvf;
    string       tag;
    @(negedge clk);
    instrWord = ins; rsVal = a; rtVal = b;
    #2;
    model(ins, a, b, eRes, eDst, eWe, eOvf, eAddr, tag);
    check(tag, "result", result, eRes, ins);
    check(tag, "destReg", {27'h0, destReg}, {27'h0, eDst}, ins);
    check(tag, "writeEn", {31'h0, writeEn}, {31'h0, eWe}, ins);
    check((eOvf ? "R4" : "R5"), "overflow", {31'h0, overflow}, {31'h0, eOvf}, ins);
    check((ins[31:26] == 6'h23 || ins[31:26] == 6'h2B) ? tag : "R13",
          "memAddr", memAddr, eAddr, ins);
  endtask

  function automatic logic [31:0] edgeVal(input logic [2:0] k, input logic [31:0] r);
    case (k)
      3'd0: return 32'h7FFF_FFFF;
      3'd1: return 32'h8000_0000;
      3'd2: return 32'h0000_0001;
      3'd3: return 32'hFFFF_FFFF;
      3'd4: return 32'h0000_0000;
      default: return r;
    endcase
  endfunction

  task automatic runAll();
    logic [31:0] ins, a, b;
    // all-zero word: shift into register 0, no write (R3, R12)
    apply(32'h0000_0000, 32'h0, 32'h0);
    // R4: add overflow 0x7fffffff + 1, rd=3
    apply({6'h00, 5'd1, 5'd2, 5'd3, 5'd0, 6'h20}, 32'h7FFF_FFFF, 32'h1);
    // R4: sub overflow 0x80000000 - 1
    apply({6'h00, 5'd1, 5'd2, 5'd4, 5'd0, 6'h22}, 32'h8000_0000, 32'h1);
    // R5: addu of the same operands writes
    apply({6'h00, 5'd1, 5'd2, 5'd3, 5'd0, 6'h21}, 32'h7FFF_FFFF, 32'h1);
    // R6: addi with negative immediate
    apply({6'h08, 5'd1, 5'd7, 16'hFFFE}, 32'd5, 32'h0);
    // R7: ori keeps immediate unsigned
    apply({6'h0D, 5'd1, 5'd7, 16'h8001}, 32'h0000_0010, 32'h0);
    // R8: lui
    apply({6'h0F, 5'd0, 5'd9, 16'hBEEF}, 32'hFFFF_FFFF, 32'h0);
    // R9 / R10: load and store addresses with negative offset
    apply({6'h23, 5'd2, 5'd8, 16'hFFF8}, 32'h0000_1000, 32'h0);
    apply({6'h2B, 5'd2, 5'd8, 16'hFFF8}, 32'h0000_1000, 32'h1234_5678);
    // R2: nor
    apply({6'h00, 5'd1, 5'd2, 5'd5, 5'd0, 6'h27}, 32'h0F0F_0000, 32'h0000_00F0);
    // R3: sll by 31, and sll with nonzero rs field (R11)
    apply({6'h00, 5'd0, 5'd2, 5'd6, 5'd31, 6'h00}, 32'h0, 32'h3);
    apply({6'h00, 5'd1, 5'd2, 5'd6, 5'd4, 6'h00}, 32'h0, 32'h3);
    // R11: arithmetic funct with nonzero shamt
    apply({6'h00, 5'd1, 5'd2, 5'd6, 5'd1, 6'h20}, 32'h5, 32'h6);
    // sweep of every op against every funct value
    for (int op = 0; op < 64; op++) begin
      for (int fn = 0; fn < 64; fn++) begin
        for (int v = 0; v < 3; v++) begin
          lfsr = nextRand(lfsr);
          ins = lfsr;
          ins[31:26] = op[5:0];
          ins[5:0] = fn[5:0];
          if (v == 0) ins[10:6] = 5'd0;
          if (v == 1) ins[25:21] = 5'd0;
          lfsr = nextRand(lfsr);
          a = (v == 2) ? lfsr : edgeVal(lfsr[2:0], lfsr);
          lfsr = nextRand(lfsr);
          b = (v == 2) ? lfsr : edgeVal(lfsr[2:0], lfsr);
          apply(ins, a, b);
        end
      end
    end
  endtask

  initial begin
    fork
      runAll();
      begin
        wait (cycles >= 150000);
        timedOut = 1;
      end
    join_any
    if (timedOut) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule